// File: doc/BRIEF.md
# Receive Status Word and Readout Sequencer

This block takes one received frame at a time and prepares it for a host that reads 16-bit words one byte at a time. When the host reads the receive event location (`evt_rd`), the block builds a 16-bit event word from the frame's length and its filter and CRC flags. It stores that word as the status entry and also shows it on `stat_word`. It then stores the frame length, limited to a maximum, as the length entry. If the frame is good, the frame bytes follow from a byte stream.

The frame bytes enter through a valid/ready stream. `rx_ready` is a registered output. It goes high only after an accepted event read that calls for frame bytes. It stays high until exactly the stored number of bytes has been taken. A byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. The source may hold `rx_valid` high or drop it at any cycle. No byte is taken while `rx_ready` is low. The frame-side flag and length inputs are sampled only on the cycle of an accepted event read.

The host reads the stored entries through a data port. Each read strobe states whether the even or the odd byte of the port is being read. The sequencer moves through three areas, in this order: the status entry at offset 0, the length entry at offset 2, and the frame words from offset 4. Each area has its own rule for which byte advances the pointer. After the last frame word the pointer returns to the status entry.

Top module: `rxstat_seq`

## Requirements
- R1: The event word starts at 0x0004. A good frame adds 0x0100. A multicast frame adds 0x0200. A hash hit adds 0x0040, but only when the frame is not multicast.
- R2: For a frame that is both good and a hash hit, the 6-bit hash index is placed in bits 14:9 (ORed with the multicast bit), and none of the R3 bits are added.
- R3: For any other frame, these bits are added: individual-address match 0x0400, broadcast 0x0800, CRC error 0x1000, raw length below MIN_LEN (64) 0x2000, raw length above MAX_LEN (1518) 0x4000.
- R4: For a good frame of even length, the stored length is min(length, MAX_LEN). For any other frame it is 0.
- R5: After an accepted event read, the block takes exactly the stored number of bytes from the stream and then drops `rx_ready`. `rx_ready` is low at all other times.
- R6: While the pointer is on the status entry or the length entry, an odd-byte read loads that word into `port_word` and advances the pointer by 2. An even-byte read changes nothing.
- R7: At the first frame word, the first even-byte read only marks entry into the frame. The next even-byte read loads the word and advances the pointer. Odd-byte reads there change nothing.
- R8: At later frame words, each even-byte read loads the word {byte 2k+1, byte 2k} and advances the pointer by 2. Odd-byte reads change nothing.
- R9: When the pointer equals 4 plus the stored length, the next read of either byte loads nothing, returns the pointer to the status entry and clears the in-frame mark.
- R10: An accepted event read places the new event word on `stat_word` and returns the pointer to the status entry. The status entry read through the port equals `stat_word`.
- R11: An odd raw length raises `len_err` until the next accepted event read. In that case no bytes are taken and the stored length is 0.
- R12: `port_word` changes only on a cycle with `rd_stb` high.
- R13: An event read while `rx_ready` is high is ignored: `stat_word`, `len_err` and the capture in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_rd | input | 1 | Read of the receive event location; starts a receive |
| frm_len | input | LEN_W | Raw frame length in bytes |
| frm_good | input | 1 | Frame has a good CRC and a valid length |
| frm_hash | input | 1 | Destination address hit the hash filter |
| frm_hidx | input | 6 | Hash table index |
| frm_mcast | input | 1 | Destination address is multicast |
| frm_indiv | input | 1 | Destination address equals the station address |
| frm_bcast | input | 1 | Destination address is broadcast |
| frm_crcerr | input | 1 | Frame had a CRC error |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Block accepts a frame byte |
| rx_data | input | 8 | Frame byte, in order of arrival |
| rd_stb | input | 1 | Host read of the data port |
| rd_odd | input | 1 | 1 = odd (upper) byte, 0 = even (lower) byte |
| stat_word | output | 16 | Last receive event word |
| port_word | output | 16 | Data port word as seen by the host |
| len_err | output | 1 | Last accepted receive had an odd length |

## Verification
The hardest state to reach from the ports is the first-frame-word entry mark. It can only be seen after both header words have been read with odd strobes, and it differs from every later frame word only by one ignored even read. A second hard case is the wrap compare for lengths clipped to the maximum. The stimulus mixes directed frames with random runs of even and odd strobes, so every entry is reached with several odd reads before the first even read and with strings of even reads. A 1600-byte frame covers the full-size store and its wrap. A reference pointer model in the bench predicts each port value.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  // event word bit values
  localparam logic [15:0] ST_BASE  = 16'h0004;
  localparam logic [15:0] ST_HASH  = 16'h0040;
  localparam logic [15:0] ST_GOOD  = 16'h0100;
  localparam logic [15:0] ST_MCAST = 16'h0200;
  localparam logic [15:0] ST_INDIV = 16'h0400;
  localparam logic [15:0] ST_BCAST = 16'h0800;
  localparam logic [15:0] ST_CRC   = 16'h1000;
  localparam logic [15:0] ST_SHORT = 16'h2000;
  localparam logic [15:0] ST_LONG  = 16'h4000;
  localparam int HIDX_LSB = 9;

  // byte offsets of the receive area entries
  localparam int OFF_STAT = 0;
  localparam int OFF_LEN  = 2;
  localparam int OFF_DATA = 4;

  typedef struct packed {
    logic       good;
    logic       hash;
    logic       mcast;
    logic       indiv;
    logic       bcast;
    logic       crcerr;
    logic [5:0] hidx;
  } rx_flags_t;
endpackage

// File: rtl/rxstat_word_gen.sv
module rxstat_word_gen
  import rxstat_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  rx_flags_t        flags,
  input  logic [LEN_W-1:0] len,
  output logic [15:0]      word,
  output logic [LEN_W-1:0] kept_len,
  output logic             odd_len
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] clipped;

  always_comb begin
    word = ST_BASE;
    if (flags.good)                word = word | ST_GOOD;
    if (flags.mcast)               word = word | ST_MCAST;
    if (flags.hash && !flags.mcast) word = word | ST_HASH;
    if (flags.good && flags.hash) begin
      word = word | (16'(flags.hidx) << HIDX_LSB);
    end else begin
      if (flags.indiv)  word = word | ST_INDIV;
      if (flags.bcast)  word = word | ST_BCAST;
      if (flags.crcerr) word = word | ST_CRC;
      if (len < MIN_L)  word = word | ST_SHORT;
      if (len > MAX_L)  word = word | ST_LONG;
    end
  end

  assign odd_len  = len[0];
  assign clipped  = (len > MAX_L) ? MAX_L : len;
  assign kept_len = (flags.good && !odd_len) ? clipped : '0;
endmodule

// File: rtl/rxstat_frame_store.sv
module rxstat_frame_store #(
  parameter int LEN_W = 11,
  parameter int DEPTH = 759,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] nbytes,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  input  logic [AW-1:0]    rd_idx,
  output logic [15:0]      rd_word
);
  logic [15:0]      mem [DEPTH];
  logic             busy_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] tot_q;
  logic [7:0]       hold_q;
  logic             take;

  assign rx_ready = busy_q;
  assign take     = busy_q && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tot_q  <= '0;
      hold_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= (nbytes != '0);
      cnt_q  <= '0;
      tot_q  <= nbytes;
    end else if (take) begin
      if (!cnt_q[0]) hold_q <= rx_data;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == tot_q - 1'b1) busy_q <= 1'b0;
    end
  end

  // byte pairs are written as one word once the odd byte arrives
  always_ff @(posedge clk) begin
    if (take && cnt_q[0]) mem[AW'(cnt_q >> 1)] <= {rx_data, hold_q};
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/rxstat_read_seq.sv
module rxstat_read_seq
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int OFF_W = 11,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             rd_stb,
  input  logic             rd_odd,
  input  logic [15:0]      stat_word,
  input  logic [LEN_W-1:0] len_word,
  input  logic [15:0]      mem_word,
  output logic [AW-1:0]    mem_idx,
  output logic [15:0]      port_word
);
  logic [OFF_W-1:0] off_q;
  logic             in_q;
  logic [OFF_W-1:0] end_off;
  logic             at_end;
  logic             load;
  logic             mark;
  logic [15:0]      sel;

  assign end_off = OFF_W'(OFF_DATA) + OFF_W'(len_word);
  assign at_end  = (off_q == end_off);
  assign mem_idx = AW'((off_q - OFF_W'(OFF_DATA)) >> 1);

  always_comb begin
    load = 1'b0;
    mark = 1'b0;
    if (!at_end) begin
      case (off_q)
        OFF_W'(OFF_STAT),
        OFF_W'(OFF_LEN):  load = rd_odd;
        OFF_W'(OFF_DATA): begin
          load = !rd_odd && in_q;
          mark = !rd_odd && !in_q;
        end
        default:          load = !rd_odd;
      endcase
    end
    if (off_q == OFF_W'(OFF_STAT))     sel = stat_word;
    else if (off_q == OFF_W'(OFF_LEN)) sel = 16'(len_word);
    else                               sel = mem_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= '0;
      in_q      <= 1'b0;
      port_word <= '0;
    end else if (restart) begin
      off_q <= '0;
      in_q  <= 1'b0;
    end else if (rd_stb) begin
      if (at_end) begin
        off_q <= '0;
        in_q  <= 1'b0;
      end else begin
        if (mark) in_q <= 1'b1;
        if (load && off_q == OFF_W'(OFF_STAT)) in_q <= 1'b0;
        if (load) begin
          port_word <= sel;
          off_q     <= off_q + OFF_W'(2);
        end
      end
    end
  end
endmodule

// File: rtl/rxstat_seq.sv
module rxstat_seq
  import rxstat_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_rd,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_good,
  input  logic             frm_hash,
  input  logic [5:0]       frm_hidx,
  input  logic             frm_mcast,
  input  logic             frm_indiv,
  input  logic             frm_bcast,
  input  logic             frm_crcerr,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rd_stb,
  input  logic             rd_odd,
  output logic [15:0]      stat_word,
  output logic [15:0]      port_word,
  output logic             len_err
);
  localparam int DEPTH = MAX_LEN / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int OFF_W = $clog2(MAX_LEN + OFF_DATA + 2);

  rx_flags_t        flags;
  logic [15:0]      new_word;
  logic [LEN_W-1:0] kept_len;
  logic             odd_len;
  logic             trig;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    mem_idx;
  logic [15:0]      mem_word;

  assign flags = '{good: frm_good, hash: frm_hash, mcast: frm_mcast,
                   indiv: frm_indiv, bcast: frm_bcast, crcerr: frm_crcerr,
                   hidx: frm_hidx};
  assign trig  = evt_rd && !rx_ready;

  rxstat_word_gen #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) gen_i (
    .flags(flags), .len(frm_len), .word(new_word),
    .kept_len(kept_len), .odd_len(odd_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_word <= '0;
      len_q     <= '0;
      len_err   <= 1'b0;
    end else if (trig) begin
      stat_word <= new_word;
      len_q     <= kept_len;
      len_err   <= odd_len;
    end
  end

  rxstat_frame_store #(.LEN_W(LEN_W), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .start(trig), .nbytes(kept_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_idx(mem_idx), .rd_word(mem_word)
  );

  rxstat_read_seq #(.LEN_W(LEN_W), .OFF_W(OFF_W), .AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .restart(trig), .rd_stb(rd_stb),
    .rd_odd(rd_odd), .stat_word(stat_word), .len_word(len_q),
    .mem_word(mem_word), .mem_idx(mem_idx), .port_word(port_word)
  );
endmodule

// File: rtl/rxstat_seq_chk.sv
module rxstat_seq_chk #(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1518
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_rd,
  input logic [LEN_W-1:0] frm_len,
  input logic             frm_good,
  input logic             frm_hash,
  input logic             frm_mcast,
  input logic             rx_ready,
  input logic             rd_stb,
  input logic [15:0]      stat_word,
  input logic [15:0]      port_word,
  input logic             len_err
);
  // R12
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(port_word));

  // R1
  base_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !rx_ready) |=> stat_word[2]);

  // R1
  mcast_nohash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !rx_ready && frm_mcast) |=> !stat_word[6]);

  // R3
  long_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !rx_ready && frm_len > LEN_W'(MAX_LEN) && !(frm_good && frm_hash))
    |=> stat_word[14]);

  // R11
  odd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !rx_ready && frm_len[0]) |=> (len_err && !rx_ready));

  // R5
  ready_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(evt_rd));

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && rx_ready) |=> ($stable(stat_word) && $stable(len_err)));
endmodule

bind rxstat_seq rxstat_seq_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_rd(evt_rd), .frm_len(frm_len),
  .frm_good(frm_good), .frm_hash(frm_hash), .frm_mcast(frm_mcast),
  .rx_ready(rx_ready), .rd_stb(rd_stb), .stat_word(stat_word),
  .port_word(port_word), .len_err(len_err)
);

// File: tb/rxstat_seq_tb_top.sv
module rxstat_seq_tb_top;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_rd = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic frm_good = 0, frm_hash = 0, frm_mcast = 0, frm_indiv = 0;
  logic frm_bcast = 0, frm_crcerr = 0;
  logic [5:0] frm_hidx = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rd_stb = 1'b0, rd_odd = 1'b0;
  logic rx_ready, len_err;
  logic [15:0] stat_word, port_word;

  int checks = 0;
  int errors = 0;
  int m_off, m_in, m_len, wrapped;
  logic [15:0] m_stat, m_port;
  logic [7:0] fb [0:2047];

  always #4 clk = ~clk;

  rxstat_seq dut_i (
    .clk(clk), .rst_n(rst_n), .evt_rd(evt_rd), .frm_len(frm_len),
    .frm_good(frm_good), .frm_hash(frm_hash), .frm_hidx(frm_hidx),
    .frm_mcast(frm_mcast), .frm_indiv(frm_indiv), .frm_bcast(frm_bcast),
    .frm_crcerr(frm_crcerr), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rd_stb(rd_stb), .rd_odd(rd_odd),
    .stat_word(stat_word), .port_word(port_word), .len_err(len_err)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(bit g, bit h, logic [5:0] idx,
      bit m, bit i, bit b, bit c, int len);
    logic [15:0] s = 16'h0004;
    if (g) s |= 16'h0100;
    if (m) s |= 16'h0200;
    if (h && !m) s |= 16'h0040;
    if (h && g) s |= {1'b0, idx, 9'b0};
    else begin
      if (i) s |= 16'h0400;
      if (b) s |= 16'h0800;
      if (c) s |= 16'h1000;
      if (len < 64) s |= 16'h2000;
      if (len > 1518) s |= 16'h4000;
    end
    return s;
  endfunction

  function automatic logic [15:0] word_at(int off);
    if (off == 0) return m_stat;
    if (off == 2) return 16'(m_len);
    return {fb[off - 3], fb[off - 4]};
  endfunction

  task automatic push(int from, int upto);
    int i = from;
    while (i < upto) begin
      @(negedge clk);
      if ($urandom % 4 == 0) rx_valid = 1'b0;
      else begin rx_valid = 1'b1; rx_data = fb[i]; end
      if (rx_valid && rx_ready) i++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic trigger(bit g, bit h, logic [5:0] idx, bit m, bit i, bit b,
      bit c, int len);
    logic [15:0] es = exp_status(g, h, idx, m, i, b, c, len);
    int kl = (g && len % 2 == 0) ? ((len > 1518) ? 1518 : len) : 0;
    @(negedge clk);
    evt_rd = 1'b1; frm_len = LEN_W'(len);
    frm_good = g; frm_hash = h; frm_hidx = idx; frm_mcast = m;
    frm_indiv = i; frm_bcast = b; frm_crcerr = c;
    @(negedge clk);
    evt_rd = 1'b0;
    chk((g && h) ? "R1 R2" : "R1 R3", stat_word, es);
    chk("R11", 16'(len_err), 16'(len % 2));
    m_stat = es; m_len = kl; m_off = 0; m_in = 0;
    for (int k = 0; k < kl; k++) fb[k] = 8'($urandom);
    chk("R5", 16'(rx_ready), 16'(kl != 0));
  endtask

  task automatic do_read(bit odd);
    string tag;
    bit ld = 0;
    int pre = m_off;
    if (m_off == 4 + m_len) begin
      m_off = 0; m_in = 0; tag = "R9"; wrapped = 1;
    end else begin
      case (m_off)
        0: begin tag = "R6 R10"; if (odd) begin ld = 1; m_in = 0; end end
        2: begin tag = "R4 R6"; if (odd) ld = 1; end
        4: begin
          tag = "R7";
          if (!odd) begin if (m_in != 0) ld = 1; else m_in = 1; end
        end
        default: begin tag = "R8"; if (!odd) ld = 1; end
      endcase
      if (ld) begin m_port = word_at(m_off); m_off += 2; end
    end
    @(negedge clk);
    rd_stb = 1'b1; rd_odd = odd;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(tag, port_word, m_port);
    if (ld && pre == 0) chk("R10", port_word, stat_word);
  endtask

  task automatic read_all();
    int n = 0;
    wrapped = 0;
    while (wrapped == 0 && n < 5000) begin
      do_read(bit'($urandom % 2));
      n++;
    end
    for (int k = 0; k < 3; k++) do_read(bit'($urandom % 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed);
    m_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset", stat_word, 16'h0000);
    chk("R12 reset", port_word, 16'h0000);
    chk("R5 reset", 16'(rx_ready), 16'h0);
    chk("R11 reset", 16'(len_err), 16'h0);

    // bad frame, regular layout; header walk with even then odd reads
    trigger(0, 0, 6'd0, 0, 1, 1, 1, 40);
    do_read(0); do_read(1); do_read(0); do_read(1); do_read(0); do_read(1);
    // good hash hit, index layout
    trigger(1, 1, 6'h2A, 0, 1, 0, 0, 8);
    chk("R2", stat_word, 16'h5544);
    push(0, m_len);
    chk("R5", 16'(rx_ready), 16'h0);
    do_read(1); do_read(1); do_read(0); do_read(1); do_read(0);
    do_read(0); do_read(1); do_read(0); do_read(0); do_read(0); do_read(1);
    // multicast with hash: no hash bit
    trigger(0, 1, 6'h3F, 1, 0, 0, 0, 100);
    chk("R1", stat_word & 16'h0040, 16'h0000);
    read_all();
    // odd length
    trigger(1, 0, 6'd0, 0, 1, 0, 0, 9);
    chk("R11", 16'(rx_ready), 16'h0);
    read_all();
    // oversize, clipped
    trigger(1, 0, 6'd0, 0, 0, 1, 0, 1600);
    push(0, m_len);
    read_all();
    // event read while capturing is ignored
    trigger(1, 0, 6'd0, 0, 1, 0, 0, 20);
    push(0, 6);
    @(negedge clk);
    evt_rd = 1'b1; frm_good = 0; frm_bcast = 1; frm_len = 11'd7;
    @(negedge clk);
    evt_rd = 1'b0;
    chk("R13", stat_word, m_stat);
    chk("R13", 16'(len_err), 16'h0);
    chk("R13", 16'(rx_ready), 16'h1);
    push(6, m_len);
    chk("R5", 16'(rx_ready), 16'h0);
    read_all();
    // idle: port holds
    repeat (5) @(negedge clk);
    chk("R12", port_word, m_port);

    for (int f = 0; f < 30; f++) begin
      int len = 2 * int'($urandom % 130);
      if (f % 10 == 9) len = 1519 + 2 * int'($urandom % 40);
      trigger(bit'($urandom % 4 != 0), bit'($urandom % 2), 6'($urandom),
              bit'($urandom % 4 == 0), bit'($urandom % 2),
              bit'($urandom % 2), bit'($urandom % 2), len);
      if (m_len > 0) push(0, m_len);
      chk("R5", 16'(rx_ready), 16'h0);
      read_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule